// File: doc/BRIEF.md
# Temperature-Scaled Refresh Interval Timer

This block paces DRAM refreshes. A counter runs for a fixed length of time and then produces a one-cycle refresh-due pulse. The length is a base interval, given in clock cycles, multiplied by a factor. That factor comes from a 3-bit temperature code that the DRAM reports. The codes are not a plain binary scale, and some code values are undefined. The block keeps a saturating count of refreshes that are due but not yet acknowledged. It also raises a sticky flag when that count would overflow.

Logic outside the block reads the temperature code from the DRAM and presents it together with a load strobe. That logic issues the refresh commands and reports each one with a single-cycle acknowledge. A newly loaded code never shortens or stretches the interval that is already counting. It applies from the next interval boundary onwards. All pins are plain level or pulse signals, so there is no back-pressure.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset, `refresh_due`, `pending_cnt`, `code_error` and `refresh_overflow` are all 0, and the active code is 3'b011, so the interval equals the base.
- R2: The interval length in cycles depends on the active code: 3'b000 gives 4×base, 3'b001 gives 2×base, 3'b011 gives base, 3'b010 gives base/2 and 3'b110 gives base/4. Division truncates.
- R3: The codes 3'b100, 3'b101 and 3'b111 are reserved. While one of them is active, `code_error` is 1 and the interval is base/4. `code_error` returns to 0 when a defined code becomes active.
- R4: Any interval that comes out shorter than 2 cycles is raised to 2 cycles.
- R5: A code loaded with `temp_load` becomes active at the next interval boundary, which is the clock edge that raises `refresh_due`. If a load falls on that boundary edge, it takes effect at once. `code_error` changes only on a boundary edge.
- R6: `refresh_due` is high for exactly one cycle per interval. The first pulse is visible in the cycle after the L-th rising edge following reset release, where L is the interval length, and later pulses come every L cycles.
- R7: Each pulse raises `pending_cnt` by 1 in the same cycle as the pulse. The count saturates at 8.
- R8: An acknowledge with no pulse lowers `pending_cnt` by 1, and is ignored when the count is 0. An acknowledge on the same edge as a pulse leaves the count unchanged. Without an acknowledge or a pulse, the count holds.
- R9: A pulse that arrives without an acknowledge while the count is 8 sets `refresh_overflow`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_cycles | input | BASE_W (16) | Base interval in clock cycles |
| temp_code | input | 3 | Temperature code from the DRAM |
| temp_load | input | 1 | Captures `temp_code` |
| refresh_ack | input | 1 | One pulse per refresh that has been issued |
| refresh_due | output | 1 | One-cycle pulse at each interval end |
| pending_cnt | output | $clog2(PEND_MAX+1) (4) | Refreshes due but not yet acknowledged |
| code_error | output | 1 | Active code is reserved |
| refresh_overflow | output | 1 | Sticky flag: a pending refresh was lost |

## Verification
`refresh_due`, `pending_cnt` and `code_error` all change on the boundary edge itself, so the bench samples each of them on the falling edge just after the pulse shows. An acknowledge driven on a falling edge is visible one falling edge later. To measure a period, the bench counts falling edges from one observed pulse to the next, and that count must equal the interval length computed for the code. A code change is checked over two measured periods. The first period, started before the load, must keep the old length. The second must have the new length.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;
  localparam logic [2:0] TC_X4   = 3'b000;
  localparam logic [2:0] TC_X2   = 3'b001;
  localparam logic [2:0] TC_X1   = 3'b011;
  localparam logic [2:0] TC_HALF = 3'b010;
  localparam logic [2:0] TC_QTR  = 3'b110;

  function automatic logic code_is_reserved(input logic [2:0] c);
    return (c == 3'b100) || (c == 3'b101) || (c == 3'b111);
  endfunction
endpackage

// File: rtl/rt_interval_scaler.sv
module rt_interval_scaler
  import refresh_timer_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int MIN_IV = 2,
  localparam int IW = BASE_W + 2
) (
  input  logic [BASE_W-1:0] base,
  input  logic [2:0]        code,
  output logic [IW-1:0]     interval
);
  logic [IW-1:0] ext;
  logic [IW-1:0] raw;

  always_comb begin
    ext = IW'(base);
    unique case (code)
      TC_X4:   raw = ext << 2;
      TC_X2:   raw = ext << 1;
      TC_X1:   raw = ext;
      TC_HALF: raw = ext >> 1;
      default: raw = ext >> 2;   // quarter and every reserved code
    endcase
    interval = (raw < IW'(MIN_IV)) ? IW'(MIN_IV) : raw;
  end
endmodule

// File: rtl/rt_code_stage.sv
module rt_code_stage
  import refresh_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code_in,
  input  logic       load,
  input  logic       boundary,
  output logic [2:0] active,
  output logic       reserved
);
  logic [2:0] staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= TC_X1;
      active <= TC_X1;
    end else begin
      if (load) staged <= code_in;
      if (boundary) active <= load ? code_in : staged;
    end
  end

  assign reserved = code_is_reserved(active);
endmodule

// File: rtl/rt_interval_counter.sv
module rt_interval_counter #(
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval,
  output logic          at_end
);
  logic [IW-1:0] cnt;

  assign at_end = (cnt >= interval - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + IW'(1);
  end
endmodule

// File: rtl/rt_pending_tracker.sv
module rt_pending_tracker #(
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ack,
  output logic [PW-1:0] count,
  output logic          overflow
);
  logic full, empty;
  assign full  = (count == PW'(PEND_MAX));
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (tick && !ack) begin
      if (full) overflow <= 1'b1;
      else      count    <= count + PW'(1);
    end else if (ack && !tick && !empty) begin
      count <= count - PW'(1);
    end
  end
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int BASE_W   = 16,
  parameter int PEND_MAX = 8,
  parameter int MIN_IV   = 2,
  localparam int IW = BASE_W + 2,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_cycles,
  input  logic [2:0]        temp_code,
  input  logic              temp_load,
  input  logic              refresh_ack,
  output logic              refresh_due,
  output logic [PW-1:0]     pending_cnt,
  output logic              code_error,
  output logic              refresh_overflow
);
  logic [2:0]    active_code;
  logic [IW-1:0] interval;
  logic          boundary;

  rt_code_stage u_stage (
    .clk(clk), .rst_n(rst_n), .code_in(temp_code), .load(temp_load),
    .boundary(boundary), .active(active_code), .reserved(code_error)
  );

  rt_interval_scaler #(.BASE_W(BASE_W), .MIN_IV(MIN_IV)) u_scale (
    .base(base_cycles), .code(active_code), .interval(interval)
  );

  rt_interval_counter #(.IW(IW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .interval(interval), .at_end(boundary)
  );

  rt_pending_tracker #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(boundary), .ack(refresh_ack),
    .count(pending_cnt), .overflow(refresh_overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refresh_due <= 1'b0;
    else        refresh_due <= boundary;
  end
endmodule

// File: rtl/rt_timer_checker.sv
module rt_timer_checker #(
  parameter int PW = 4,
  parameter int PEND_MAX = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          refresh_ack,
  input logic          refresh_due,
  input logic [PW-1:0] pending_cnt,
  input logic          code_error,
  input logic          refresh_overflow
);
  // R6: the pulse never lasts two cycles
  a_r6_due_single: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_due |=> !refresh_due);
  // R7: count never passes the ceiling
  a_r7_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pending_cnt <= PW'(PEND_MAX));
  // R8: without acknowledge or pulse the count holds
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_ack |=> (refresh_due || $stable(pending_cnt)));
  // R9: overflow is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_overflow |=> refresh_overflow);
  // R9: overflow rises only with a pulse at a full count
  a_r9_ovf_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_overflow) |-> (refresh_due && pending_cnt == PW'(PEND_MAX)));
  // R5: error flag moves only on a boundary
  a_r5_err_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_error) |-> refresh_due);
endmodule

bind refresh_interval_timer rt_timer_checker #(.PW(PW), .PEND_MAX(PEND_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .refresh_ack(refresh_ack), .refresh_due(refresh_due),
  .pending_cnt(pending_cnt), .code_error(code_error),
  .refresh_overflow(refresh_overflow)
);

// File: tb/refresh_interval_timer_tb_top.sv
module refresh_interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BASE_W-1:0] base_cycles = 16'd8;
  logic [2:0] temp_code = 3'b011;
  logic temp_load = 1'b0;
  logic refresh_ack = 1'b0;
  logic refresh_due;
  logic [3:0] pending_cnt;
  logic code_error;
  logic refresh_overflow;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  refresh_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .base_cycles(base_cycles), .temp_code(temp_code),
    .temp_load(temp_load), .refresh_ack(refresh_ack), .refresh_due(refresh_due),
    .pending_cnt(pending_cnt), .code_error(code_error),
    .refresh_overflow(refresh_overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // count falling edges until refresh_due is seen high
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!refresh_due && n < 500);
  endtask

  function automatic int exp_len(input int b, input logic [2:0] c);
    int v;
    case (c)
      3'b000: v = b * 4;
      3'b001: v = b * 2;
      3'b011: v = b;
      3'b010: v = b / 2;
      default: v = b / 4;
    endcase
    return (v < 2) ? 2 : v;
  endfunction

  task automatic load_code(input logic [2:0] c);
    temp_code = c;
    temp_load = 1'b1;
    @(negedge clk);
    temp_load = 1'b0;
  endtask

  initial begin
    int n;
    int bases[2] = '{3, 8};

    // R1 / R6: reset state and first pulse
    base_cycles = 16'd8;
    do_reset();
    check("R1 due", int'(refresh_due), 0);
    check("R1 pending", int'(pending_cnt), 0);
    check("R1 error", int'(code_error), 0);
    check("R1 overflow", int'(refresh_overflow), 0);
    wait_pulse(n);
    check("R6 first pulse", n, 8);
    check("R7 pending after pulse", int'(pending_cnt), 1);
    @(negedge clk);
    check("R6 single cycle", int'(refresh_due), 0);

    // R2 / R3 / R4 / R8: sweep every code on two bases, ack held high
    foreach (bases[bi]) begin
      base_cycles = 16'(bases[bi]);
      refresh_ack = 1'b1;
      do_reset();
      for (int c = 0; c < 8; c++) begin
        load_code(3'(c));
        wait_pulse(n);
        wait_pulse(n);
        check("R2 R3 R4 period", n, exp_len(bases[bi], 3'(c)));
        check("R3 error flag", int'(code_error),
              (c == 4 || c == 5 || c == 7) ? 1 : 0);
        check("R8 ack with pulse keeps zero", int'(pending_cnt), 0);
      end
    end

    // R5: load mid-interval keeps the running interval
    base_cycles = 16'd8;
    refresh_ack = 1'b1;
    do_reset();
    wait_pulse(n);
    repeat (2) @(negedge clk);
    load_code(3'b000);
    wait_pulse(n);
    check("R5 old interval kept", n, 5);
    wait_pulse(n);
    check("R5 new interval", n, 32);
    load_code(3'b100);
    check("R5 error waits for boundary", int'(code_error), 0);
    wait_pulse(n);
    check("R3 error at boundary", int'(code_error), 1);
    wait_pulse(n);
    check("R3 reserved quarter", n, 2);
    load_code(3'b011);
    wait_pulse(n);
    check("R3 error clears", int'(code_error), 0);
    wait_pulse(n);
    check("R5 back to base", n, 8);

    // R7 / R8 / R9: saturation, overflow, acknowledges
    base_cycles = 16'd4;
    refresh_ack = 1'b0;
    do_reset();
    for (int i = 1; i <= 9; i++) begin
      wait_pulse(n);
      check("R7 pending count", int'(pending_cnt), (i > 8) ? 8 : i);
      check("R9 overflow", int'(refresh_overflow), (i > 8) ? 1 : 0);
    end
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check("R8 ack decrements", int'(pending_cnt), 7);
    repeat (2) @(negedge clk);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check("R6 pulse on ack edge", int'(refresh_due), 1);
    check("R8 ack with pulse holds", int'(pending_cnt), 7);
    refresh_ack = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 drained", int'(pending_cnt), 0);
    repeat (10) @(negedge clk);
    check("R8 ack at zero ignored", int'(pending_cnt), 0);
    check("R9 overflow sticky", int'(refresh_overflow), 1);
    refresh_ack = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule